// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block sits beside a UART's transmit, receive and modem logic and turns four raw interrupt conditions into one interrupt line and an identification byte. The four sources are line-status errors, received data available, transmit holding register empty and modem-status change. Each source is latched in its own pending flag. The flag is cleared by the CPU action that services that source. A 4-bit enable register selects which pending flags count. The interrupt line is further gated by a global enable bit, which comes from the modem control register outside this block.

The identification byte reports the highest-priority enabled pending source. It is registered, and it is held steady for as long as the CPU read strobe for it stays high. A source that arrives in the middle of a read therefore cannot corrupt the value being read. All pins are plain control and status signals. No data stream flows through the block, so there is no valid/ready handshake.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register is written with `ier_wr`. Bit 0 enables data available, bit 1 enables holding register empty, bit 2 enables line status and bit 3 enables modem status. `ier_rdata` returns these four bits, and bits 7-4 read as 0.
- R2: After reset, `iir_data` is 0x01, `irq` is 0 and `ier_rdata` is 0x00.
- R3: `iir_data` bit 0 is 0 while any enabled source is pending. Bits 2-1 then hold the highest-priority source: 11 for line status, 10 for data available, 01 for holding register empty, 00 for modem status. The priority order is the same as the code order, line status highest.
- R4: A pending source whose enable bit is 0 neither drives `irq` nor appears in `iir_data`. Its flag is kept, so setting the enable bit later reports it.
- R5: `irq` is high only when `gie` is 1 and at least one enabled source is pending. `gie` does not change `iir_data`.
- R6: While `rd_iir` stays high, `iir_data` holds the value it had when the read began. When `rd_iir` drops, `iir_data` is updated.
- R7: The line-status source is set by an `ls_evt` pulse and cleared by `rd_lsr`.
- R8: The data-available source is set by a rising edge of `rx_avail`. It is cleared by `rd_rbr` or by `rx_avail` going low.
- R9: The holding-register-empty source is set by a rising edge of `thr_empty` and cleared by `wr_thr`. It is also cleared by the start of an `rd_iir` read, but only when `iir_data` is showing that source (0x02) at that moment.
- R10: The modem-status source is set by an `ms_evt` pulse and cleared by `rd_msr`.
- R11: Writing bit 1 of the enable register from 0 to 1 while `thr_empty` is high sets the holding-register-empty source at once.
- R12: Bits 7-3 of `iir_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register readback |
| gie | input | 1 | Global interrupt enable |
| ls_evt | input | 1 | Line-status error event pulse |
| rx_avail | input | 1 | Receive data ready level |
| thr_empty | input | 1 | Transmit holding register empty level |
| ms_evt | input | 1 | Modem-status change event pulse |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line-status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_msr | input | 1 | Modem-status register read strobe |
| wr_thr | input | 1 | Holding register write strobe |
| iir_data | output | 8 | Identification byte |
| irq | output | 1 | Interrupt output |

## Verification
Single sources are raised on their own to check each identity code. Then several sources are stacked, and they are cleared from the top down, so the reported code steps through the priority order; this separates a correct encoder from one with swapped ranks. Reading the identification byte while line status is pending shows that a read clears the transmit source only when that source is the one reported. A second source raised in the middle of a held read tells a frozen register apart from a transparent one. Changing the mask and `gie` while a source is pending shows that masking hides the source without dropping its flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [1:0] {
    ID_MODEM  = 2'b00,
    ID_THRE   = 2'b01,
    ID_RXDATA = 2'b10,
    ID_LINE   = 2'b11
  } irq_id_e;

  localparam int NSRC      = 4;
  localparam int SRC_RXD   = 0;
  localparam int SRC_THRE  = 1;
  localparam int SRC_LINE  = 2;
  localparam int SRC_MODEM = 3;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // set wins over clear so an event coinciding with service is not lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act_i,
  output logic            any_o,
  output irq_id_e         id_o
);
  always_comb begin
    any_o = |act_i;
    if (act_i[SRC_LINE])       id_o = ID_LINE;
    else if (act_i[SRC_RXD])   id_o = ID_RXDATA;
    else if (act_i[SRC_THRE])  id_o = ID_THRE;
    else                       id_o = ID_MODEM;
  end
endmodule

// File: rtl/uart_irq_idreg.sv
module uart_irq_idreg
  import uart_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          any_i,
  input  irq_id_e       id_i,
  output logic [DW-1:0] idv_o,
  output logic          rd_start_o
);
  localparam logic [DW-1:0] IDLE_V = DW'(1);

  logic [DW-1:0] nxt;
  logic          hold_d;

  always_comb begin
    nxt = IDLE_V;
    if (any_i) nxt = {{(DW-3){1'b0}}, id_i, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idv_o  <= IDLE_V;
      hold_d <= 1'b0;
    end else begin
      hold_d <= hold_i;
      if (!hold_i) idv_o <= nxt;
    end
  end

  assign rd_start_o = hold_i & ~hold_d;

  assert_id_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && $past(hold_i)) |-> $stable(idv_o));

  assert_id_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    idv_o[DW-1:3] == '0);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ier_wr,
  input  logic [DW-1:0] ier_wdata,
  output logic [DW-1:0] ier_rdata,
  input  logic          gie,
  input  logic          ls_evt,
  input  logic          rx_avail,
  input  logic          thr_empty,
  input  logic          ms_evt,
  input  logic          rd_iir,
  input  logic          rd_lsr,
  input  logic          rd_rbr,
  input  logic          rd_msr,
  input  logic          wr_thr,
  output logic [DW-1:0] iir_data,
  output logic          irq
);
  localparam logic [2:0] THRE_CODE = {ID_THRE, 1'b0};

  logic [NSRC-1:0] en_q, set_v, clr_v, pend_v, act_v;
  logic            rx_d, thr_d, any, rd_start;
  irq_id_e         top_id;

  // enable register and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      rx_d  <= 1'b0;
      thr_d <= 1'b1;
    end else begin
      rx_d  <= rx_avail;
      thr_d <= thr_empty;
      if (ier_wr) en_q <= ier_wdata[NSRC-1:0];
    end
  end

  assign ier_rdata = {{(DW-NSRC){1'b0}}, en_q};

  // per-source set and clear conditions
  always_comb begin
    set_v[SRC_LINE]  = ls_evt;
    clr_v[SRC_LINE]  = rd_lsr;
    set_v[SRC_RXD]   = rx_avail & ~rx_d;
    clr_v[SRC_RXD]   = rd_rbr | ~rx_avail;
    set_v[SRC_THRE]  = (thr_empty & ~thr_d)
                     | (ier_wr & ier_wdata[SRC_THRE] & ~en_q[SRC_THRE] & thr_empty);
    clr_v[SRC_THRE]  = wr_thr | (rd_start & (iir_data[2:0] == THRE_CODE));
    set_v[SRC_MODEM] = ms_evt;
    clr_v[SRC_MODEM] = rd_msr;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    uart_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .pend_o (pend_v[g])
    );
  end

  assign act_v = pend_v & en_q;

  uart_irq_prio u_prio (
    .act_i (act_v),
    .any_o (any),
    .id_o  (top_id)
  );

  uart_irq_idreg #(.DW(DW)) u_idreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (rd_iir),
    .any_i      (any),
    .id_i       (top_id),
    .idv_o      (iir_data),
    .rd_start_o (rd_start)
  );

  assign irq = gie & any;

  assert_line_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !ls_evt) |=> !pend_v[SRC_LINE]);

  assert_rx_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_avail |=> !pend_v[SRC_RXD]);

  assert_thr_write_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !set_v[SRC_THRE]) |=> !pend_v[SRC_THRE]);

  assert_modem_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !ms_evt) |=> !pend_v[SRC_MODEM]);
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_wr = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic [7:0] ier_rdata;
  logic       gie = 1'b0, ls_evt = 1'b0, rx_avail = 1'b0, thr_empty = 1'b0, ms_evt = 1'b0;
  logic       rd_iir = 1'b0, rd_lsr = 1'b0, rd_rbr = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
  logic [7:0] iir_data;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [7:0] iir;
    logic       irq;
    logic [7:0] ier;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
    .gie(gie), .ls_evt(ls_evt), .rx_avail(rx_avail), .thr_empty(thr_empty), .ms_evt(ms_evt),
    .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .iir_data(iir_data), .irq(irq)
  );

  // monitor: pops one expectation per edge, samples 2 ns after it
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (iir_data !== e.iir || irq !== e.irq || ier_rdata !== e.ier) begin
        failures++;
        $display("FAIL %s: iir=%02h irq=%0b ier=%02h expected iir=%02h irq=%0b ier=%02h",
                 e.tag, iir_data, irq, ier_rdata, e.iir, e.irq, e.ier);
      end
    end
  end

  task automatic push(string tag, logic [7:0] iv, logic ir, logic [7:0] ev);
    exp_t e;
    e.tag = tag; e.iir = iv; e.irq = ir; e.ier = ev;
    q.push_back(e);
  endtask

  // let state settle, then expect at the next edge
  task automatic chk(string tag, logic [7:0] iv, logic ir, logic [7:0] ev);
    repeat (2) @(posedge clk);
    push(tag, iv, ir, ev);
    @(negedge clk);
  endtask

  task automatic pulse(string which);
    @(negedge clk);
    case (which)
      "ls":  ls_evt = 1'b1;
      "ms":  ms_evt = 1'b1;
      "iir": rd_iir = 1'b1;
      "lsr": rd_lsr = 1'b1;
      "rbr": rd_rbr = 1'b1;
      "msr": rd_msr = 1'b1;
      "thr": wr_thr = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    {ls_evt, ms_evt, rd_iir, rd_lsr, rd_rbr, rd_msr, wr_thr} = '0;
  endtask

  task automatic wr_ier(logic [7:0] v);
    @(negedge clk);
    ier_wr = 1'b1; ier_wdata = v;
    @(negedge clk);
    ier_wr = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R2 reset state", 8'h01, 1'b0, 8'h00);

    wr_ier(8'hFF);
    chk("R1 enable readback upper zero, R12", 8'h01, 1'b0, 8'h0F);
    gie = 1'b1;

    pulse("ls");
    chk("R3 line status code", 8'h06, 1'b1, 8'h0F);
    pulse("lsr");
    chk("R7 line status cleared", 8'h01, 1'b0, 8'h0F);

    pulse("ms");
    @(negedge clk) rx_avail = 1'b1;
    pulse("ls");
    chk("R3 line over data/modem", 8'h06, 1'b1, 8'h0F);
    pulse("lsr");
    chk("R3 data over modem", 8'h04, 1'b1, 8'h0F);
    pulse("rbr");
    chk("R8 rbr read clears data", 8'h00, 1'b1, 8'h0F);
    pulse("msr");
    chk("R10 modem cleared", 8'h01, 1'b0, 8'h0F);

    @(negedge clk) rx_avail = 1'b0;
    @(negedge clk) rx_avail = 1'b1;
    chk("R8 rising ready sets data", 8'h04, 1'b1, 8'h0F);
    @(negedge clk) rx_avail = 1'b0;
    chk("R8 falling ready clears data", 8'h01, 1'b0, 8'h0F);

    wr_ier(8'h0B);
    pulse("ls");
    chk("R4 masked line status hidden", 8'h01, 1'b0, 8'h0B);
    wr_ier(8'h0F);
    chk("R4 unmask shows kept flag", 8'h06, 1'b1, 8'h0F);
    pulse("lsr");

    pulse("ms");
    gie = 1'b0;
    chk("R5 gie low blocks irq", 8'h00, 1'b0, 8'h0F);
    gie = 1'b1;
    chk("R5 gie high passes irq", 8'h00, 1'b1, 8'h0F);
    pulse("msr");

    wr_ier(8'h0D);
    @(negedge clk) thr_empty = 1'b1;
    pulse("thr");
    chk("R9 holding write clears", 8'h01, 1'b0, 8'h0D);
    wr_ier(8'h0F);
    chk("R11 enable while empty sets", 8'h02, 1'b1, 8'h0F);

    pulse("ls");
    chk("R3 line over holding", 8'h06, 1'b1, 8'h0F);
    pulse("iir");
    pulse("lsr");
    chk("R9 id read of other source keeps holding", 8'h02, 1'b1, 8'h0F);

    // held read with a higher source arriving mid-read
    @(negedge clk);
    rd_iir = 1'b1; ls_evt = 1'b1;
    @(posedge clk);
    push("R6 frozen at read start", 8'h02, 1'b1, 8'h0F);
    @(negedge clk) ls_evt = 1'b0;
    @(posedge clk);
    push("R6 still frozen", 8'h02, 1'b1, 8'h0F);
    @(negedge clk) rd_iir = 1'b0;
    chk("R6 updates after read", 8'h06, 1'b1, 8'h0F);
    pulse("lsr");
    chk("R9 id read cleared holding", 8'h01, 1'b0, 8'h0F);

    @(negedge clk) thr_empty = 1'b0;
    @(negedge clk) thr_empty = 1'b1;
    chk("R9 empty rise sets holding", 8'h02, 1'b1, 8'h0F);
    pulse("thr");
    chk("R9 write clears holding", 8'h01, 1'b0, 8'h0F);

    repeat (4) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule